// File: doc/BRIEF.md
# Two-Level Bus Fabric with 64-to-32 IO Narrowing

This block sits between a processor's single 64-bit Wishbone master port and the slaves of a small system. It decodes the upper address bits into one of three legs: a block RAM leg, a DRAM leg, or a shared IO leg. A fourth address region is unmapped and answers with an error acknowledge, so the master is never left waiting. Only the chosen leg sees cycle and strobe, and the master's acknowledge and read data come only from that leg.

The IO leg is registered and then narrowed to 32-bit data. It carries one access at a time. Each 64-bit access becomes one or two 32-bit beats. The byte-select halves decide how many beats there are. When both halves are selected, the low word goes first. A second decoder on the narrow side picks one of the IO peripherals from a 4-bit field of the address. An index that matches no peripheral is acknowledged locally with all-ones read data. Splitting the decode this way keeps the wide master path short and moves the peripheral fan-out behind a register.

Top module: `soc_bus_fabric`

## Requirements
- R1: Address bits [29:28] pick the leg. 00 is block RAM, 01 is DRAM and 11 is IO. Only the chosen leg sees cycle and strobe. Master ack and read data come from that leg alone. A block RAM access completes one clock after it is presented, when the slave has a one-cycle acknowledge.
- R2: Region 10 returns an error acknowledge (`m_err`) in the same cycle as the strobe. No leg is strobed and `m_ack` stays low.
- R3: On an IO access where only one half is selected, exactly one 32-bit beat is made. Lanes [3:0] select the low word and lanes [7:4] the high word. The returned word sits on the matching 64-bit lane, and the other half reads as zero.
- R4: On an IO access with both halves selected, two beats are made. The low word goes first (narrow address bit 2 = 0) and the high word second (bit 2 = 1). The master is acknowledged only after the second beat.
- R5: The register stage costs one cycle in each direction. Only one IO access is outstanding. With a peripheral that acknowledges one cycle after its strobe, a single-beat IO access completes 3 clocks after it is presented and a two-beat access completes after 5 clocks.
- R6: Address bits [15:12] on the narrow side pick the peripheral. Values 0 to NUM_IO-1 each strobe only their own peripheral.
- R7: An IO index that matches no peripheral is acknowledged locally with all-ones data on each beat. A one-beat access completes after 2 clocks and a two-beat access after 3 clocks.
- R8: On a write, the low beat carries `m_dat_w[31:0]` with lanes [3:0]. The high beat carries `m_dat_w[63:32]` with lanes [7:4].
- R9: After reset, `m_ack`, `m_err` and every leg and peripheral strobe are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_cyc | input | 1 | Master cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | ADDR_W | Master byte address |
| m_sel | input | DW/8 | Master byte lanes |
| m_dat_w | input | DW | Master write data |
| m_dat_r | output | DW | Master read data |
| m_ack | output | 1 | Master acknowledge |
| m_err | output | 1 | Error acknowledge for the unmapped region |
| bram_cyc | output | 1 | Block RAM cycle |
| bram_stb | output | 1 | Block RAM strobe |
| bram_we | output | 1 | Block RAM write enable |
| bram_adr | output | ADDR_W | Block RAM address |
| bram_sel | output | DW/8 | Block RAM byte lanes |
| bram_dat_w | output | DW | Block RAM write data |
| bram_dat_r | input | DW | Block RAM read data |
| bram_ack | input | 1 | Block RAM acknowledge |
| dram_cyc | output | 1 | DRAM cycle |
| dram_stb | output | 1 | DRAM strobe |
| dram_we | output | 1 | DRAM write enable |
| dram_adr | output | ADDR_W | DRAM address |
| dram_sel | output | DW/8 | DRAM byte lanes |
| dram_dat_w | output | DW | DRAM write data |
| dram_dat_r | input | DW | DRAM read data |
| dram_ack | input | 1 | DRAM acknowledge |
| io_cyc | output | NUM_IO | Per-peripheral cycle |
| io_stb | output | NUM_IO | Per-peripheral strobe |
| io_we | output | 1 | Narrow write enable |
| io_adr | output | ADDR_W | Narrow byte address (bit 2 selects the word) |
| io_sel | output | HW/8 | Narrow byte lanes |
| io_dat_w | output | HW | Narrow write data |
| io_dat_r | input | NUM_IO*HW | Packed peripheral read data, peripheral p at [p*HW +: HW] |
| io_ack | input | NUM_IO | Per-peripheral acknowledge |

## Verification
The main risk is a fault in the narrowing bridge's half pointer or state. Such a fault shows at the peripheral ports as a missing beat, a doubled beat or a high-before-low order. At the master it shows as read data on the wrong lane or a completion that comes one or two clocks early or late, all within the five clocks of one access. If the bridge is stuck in its reply state, the master sees a repeated or missing acknowledge on the next access. A decode error in either level strobes the wrong slave. The error then surfaces as read data from the wrong memory or as a second strobe in the same cycle.

// File: rtl/fabric_pkg.sv
`timescale 1ns/1ps
package fabric_pkg;
  // Region code taken from the two top address bits.
  typedef enum logic [1:0] {
    RGN_BRAM = 2'b00,
    RGN_DRAM = 2'b01,
    RGN_HOLE = 2'b10,
    RGN_IO   = 2'b11
  } region_e;

  localparam int LEG_BRAM = 0;
  localparam int LEG_DRAM = 1;
  localparam int LEG_IO   = 2;
  localparam int NUM_LEGS = 3;

  typedef enum logic [1:0] {BR_IDLE, BR_XFER, BR_REPLY} bridge_st_e;

  function automatic int leg_of(input region_e r);
    case (r)
      RGN_BRAM: return LEG_BRAM;
      RGN_DRAM: return LEG_DRAM;
      RGN_IO:   return LEG_IO;
      default:  return NUM_LEGS;
    endcase
  endfunction

  // First beat is the high word only when no low lane is selected.
  function automatic logic begins_high(input logic lo_any, input logic hi_any);
    return hi_any && !lo_any;
  endfunction

  function automatic logic needs_two(input logic lo_any, input logic hi_any);
    return lo_any && hi_any;
  endfunction
endpackage

// File: rtl/fab_top_decode.sv
`timescale 1ns/1ps
module fab_top_decode import fabric_pkg::*; #(
  parameter int DW = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   m_cyc,
  input  logic                   m_stb,
  input  logic [1:0]             m_region,
  output logic                   m_ack,
  output logic                   m_err,
  output logic [DW-1:0]          m_dat_r,
  output logic [NUM_LEGS-1:0]    t_cyc,
  output logic [NUM_LEGS-1:0]    t_stb,
  input  logic [NUM_LEGS-1:0]    t_ack,
  input  logic [NUM_LEGS*DW-1:0] t_dat_r
);
  region_e rgn;
  int      leg;
  logic    hit;

  assign rgn = region_e'(m_region);
  assign leg = leg_of(rgn);
  assign hit = (rgn != RGN_HOLE);

  for (genvar s = 0; s < NUM_LEGS; s++) begin : g_leg
    assign t_cyc[s] = m_cyc && hit && (leg == s);
    assign t_stb[s] = m_cyc && m_stb && hit && (leg == s);
  end

  always_comb begin
    m_ack   = 1'b0;
    m_dat_r = '0;
    for (int s = 0; s < NUM_LEGS; s++) begin
      if (hit && leg == s) begin
        m_ack   = t_ack[s];
        m_dat_r = t_dat_r[s*DW +: DW];
      end
    end
  end

  assign m_err = m_cyc && m_stb && !hit;

  AST_ONE_LEG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({t_stb, m_err})); // R1
  AST_ERR_NOT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> !m_ack && (t_stb == '0)); // R2
endmodule

// File: rtl/io_narrow_bridge.sv
`timescale 1ns/1ps
module io_narrow_bridge import fabric_pkg::*; #(
  parameter int ADDR_W = 30,
  parameter int DW     = 64,
  parameter int HW     = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              up_cyc,
  input  logic                              up_stb,
  input  logic                              up_we,
  input  logic [ADDR_W-$clog2(DW/8)-1:0]    up_adrw,
  input  logic [DW/8-1:0]                   up_sel,
  input  logic [DW-1:0]                     up_dat_w,
  output logic                              up_ack,
  output logic [DW-1:0]                     up_dat_r,
  output logic                              dn_cyc,
  output logic                              dn_stb,
  output logic                              dn_we,
  output logic [ADDR_W-1:0]                 dn_adr,
  output logic [HW/8-1:0]                   dn_sel,
  output logic [HW-1:0]                     dn_dat_w,
  input  logic                              dn_ack,
  input  logic [HW-1:0]                     dn_dat_r
);
  localparam int SW       = DW / 8;
  localparam int HSW      = HW / 8;
  localparam int HALF_LSB = $clog2(HSW);
  localparam int AWW      = ADDR_W - $clog2(SW);

  bridge_st_e     st;
  logic           on_hi, two;
  logic           r_we;
  logic [AWW-1:0] r_adrw;
  logic [SW-1:0]  r_sel;
  logic [DW-1:0]  r_wd, r_rd;

  // Named internal events.
  logic lo_any, hi_any, accept, beat_done, step_half, last_beat;
  assign lo_any    = |up_sel[HSW-1:0];
  assign hi_any    = |up_sel[SW-1:HSW];
  assign accept    = (st == BR_IDLE) && up_cyc && up_stb;
  assign beat_done = (st == BR_XFER) && dn_ack;
  assign step_half = beat_done && !on_hi && two;
  assign last_beat = beat_done && !step_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= BR_IDLE; on_hi <= 1'b0; two <= 1'b0; r_we <= 1'b0;
      r_adrw <= '0; r_sel <= '0; r_wd <= '0; r_rd <= '0;
    end else begin
      case (st)
        BR_IDLE: if (accept) begin
          st     <= BR_XFER;
          on_hi  <= begins_high(lo_any, hi_any);
          two    <= needs_two(lo_any, hi_any);
          r_we   <= up_we;
          r_adrw <= up_adrw;
          r_sel  <= up_sel;
          r_wd   <= up_dat_w;
          r_rd   <= '0;
        end
        BR_XFER: if (beat_done) begin
          if (on_hi) r_rd[DW-1:HW] <= dn_dat_r;
          else       r_rd[HW-1:0]  <= dn_dat_r;
          if (step_half) on_hi <= 1'b1;
          if (last_beat) st    <= BR_REPLY;
        end
        BR_REPLY: st <= BR_IDLE;
        default:  st <= BR_IDLE;
      endcase
    end
  end

  assign dn_cyc   = (st == BR_XFER);
  assign dn_stb   = (st == BR_XFER);
  assign dn_we    = r_we;
  assign dn_adr   = {r_adrw, on_hi, {HALF_LSB{1'b0}}};
  assign dn_sel   = on_hi ? r_sel[SW-1:HSW] : r_sel[HSW-1:0];
  assign dn_dat_w = on_hi ? r_wd[DW-1:HW]   : r_wd[HW-1:0];
  assign up_ack   = (st == BR_REPLY);
  assign up_dat_r = r_rd;

  AST_ACK_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack |-> $past(dn_ack)); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack |-> !dn_stb); // R5
  AST_LOW_BEFORE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    dn_stb && $past(dn_stb) && $rose(dn_adr[HALF_LSB]) |-> $past(dn_ack)); // R4
  AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    dn_stb && !dn_ack |=> dn_stb && $stable(dn_adr)); // R5
endmodule

// File: rtl/io_periph_decode.sv
`timescale 1ns/1ps
module io_periph_decode #(
  parameter int HW     = 32,
  parameter int NUM_IO = 4,
  parameter int IDX_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 leg_cyc,
  input  logic                 leg_stb,
  input  logic [IDX_W-1:0]     leg_idx,
  output logic                 leg_ack,
  output logic [HW-1:0]        leg_dat_r,
  output logic [NUM_IO-1:0]    p_cyc,
  output logic [NUM_IO-1:0]    p_stb,
  input  logic [NUM_IO-1:0]    p_ack,
  input  logic [NUM_IO*HW-1:0] p_dat_r
);
  logic matched;
  assign matched = int'(leg_idx) < NUM_IO;

  for (genvar g = 0; g < NUM_IO; g++) begin : g_per
    assign p_cyc[g] = leg_cyc && (int'(leg_idx) == g);
    assign p_stb[g] = leg_cyc && leg_stb && (int'(leg_idx) == g);
  end

  always_comb begin
    leg_ack   = leg_cyc && leg_stb;
    leg_dat_r = '1;
    for (int g = 0; g < NUM_IO; g++) begin
      if (matched && int'(leg_idx) == g) begin
        leg_ack   = p_ack[g];
        leg_dat_r = p_dat_r[g*HW +: HW];
      end
    end
  end

  AST_ONE_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p_stb)); // R6
  AST_NO_HANG: assert property (@(posedge clk) disable iff (!rst_n)
    leg_cyc && leg_stb && !matched |-> leg_ack && (p_stb == '0)); // R7
endmodule

// File: rtl/soc_bus_fabric.sv
`timescale 1ns/1ps
module soc_bus_fabric import fabric_pkg::*; #(
  parameter int ADDR_W  = 30,
  parameter int DW      = 64,
  parameter int HW      = 32,
  parameter int NUM_IO  = 4,
  parameter int IDX_LSB = 12,
  parameter int IDX_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 m_cyc,
  input  logic                 m_stb,
  input  logic                 m_we,
  input  logic [ADDR_W-1:0]    m_adr,
  input  logic [DW/8-1:0]      m_sel,
  input  logic [DW-1:0]        m_dat_w,
  output logic [DW-1:0]        m_dat_r,
  output logic                 m_ack,
  output logic                 m_err,
  output logic                 bram_cyc,
  output logic                 bram_stb,
  output logic                 bram_we,
  output logic [ADDR_W-1:0]    bram_adr,
  output logic [DW/8-1:0]      bram_sel,
  output logic [DW-1:0]        bram_dat_w,
  input  logic [DW-1:0]        bram_dat_r,
  input  logic                 bram_ack,
  output logic                 dram_cyc,
  output logic                 dram_stb,
  output logic                 dram_we,
  output logic [ADDR_W-1:0]    dram_adr,
  output logic [DW/8-1:0]      dram_sel,
  output logic [DW-1:0]        dram_dat_w,
  input  logic [DW-1:0]        dram_dat_r,
  input  logic                 dram_ack,
  output logic [NUM_IO-1:0]    io_cyc,
  output logic [NUM_IO-1:0]    io_stb,
  output logic                 io_we,
  output logic [ADDR_W-1:0]    io_adr,
  output logic [HW/8-1:0]      io_sel,
  output logic [HW-1:0]        io_dat_w,
  input  logic [NUM_IO*HW-1:0] io_dat_r,
  input  logic [NUM_IO-1:0]    io_ack
);
  localparam int WORD_LSB = $clog2(DW/8);

  logic [NUM_LEGS-1:0]    t_cyc, t_stb, t_ack;
  logic [NUM_LEGS*DW-1:0] t_dat_r;
  logic                   leg_ack;
  logic [DW-1:0]          leg_dat_r;
  logic                   n_cyc, n_stb, n_ack;
  logic [HW-1:0]          n_dat_r;

  fab_top_decode #(.DW(DW)) u_lvl1 (
    .clk(clk), .rst_n(rst_n), .m_cyc(m_cyc), .m_stb(m_stb),
    .m_region(m_adr[ADDR_W-1 -: 2]), .m_ack(m_ack), .m_err(m_err),
    .m_dat_r(m_dat_r), .t_cyc(t_cyc), .t_stb(t_stb), .t_ack(t_ack),
    .t_dat_r(t_dat_r)
  );

  assign t_ack   = {leg_ack, dram_ack, bram_ack};
  assign t_dat_r = {leg_dat_r, dram_dat_r, bram_dat_r};

  assign bram_cyc = t_cyc[LEG_BRAM];  assign bram_stb = t_stb[LEG_BRAM];
  assign dram_cyc = t_cyc[LEG_DRAM];  assign dram_stb = t_stb[LEG_DRAM];
  assign bram_we  = m_we;  assign bram_adr = m_adr;
  assign bram_sel = m_sel; assign bram_dat_w = m_dat_w;
  assign dram_we  = m_we;  assign dram_adr = m_adr;
  assign dram_sel = m_sel; assign dram_dat_w = m_dat_w;

  io_narrow_bridge #(.ADDR_W(ADDR_W), .DW(DW), .HW(HW)) u_bridge (
    .clk(clk), .rst_n(rst_n),
    .up_cyc(t_cyc[LEG_IO]), .up_stb(t_stb[LEG_IO]), .up_we(m_we),
    .up_adrw(m_adr[ADDR_W-1:WORD_LSB]), .up_sel(m_sel), .up_dat_w(m_dat_w),
    .up_ack(leg_ack), .up_dat_r(leg_dat_r),
    .dn_cyc(n_cyc), .dn_stb(n_stb), .dn_we(io_we), .dn_adr(io_adr),
    .dn_sel(io_sel), .dn_dat_w(io_dat_w), .dn_ack(n_ack), .dn_dat_r(n_dat_r)
  );

  io_periph_decode #(.HW(HW), .NUM_IO(NUM_IO), .IDX_W(IDX_W)) u_lvl2 (
    .clk(clk), .rst_n(rst_n), .leg_cyc(n_cyc), .leg_stb(n_stb),
    .leg_idx(io_adr[IDX_LSB +: IDX_W]), .leg_ack(n_ack), .leg_dat_r(n_dat_r),
    .p_cyc(io_cyc), .p_stb(io_stb), .p_ack(io_ack), .p_dat_r(io_dat_r)
  );

  AST_IO_QUIET_OFF_LEG: assert property (@(posedge clk) disable iff (!rst_n)
    (bram_stb || dram_stb || m_err) |-> (io_stb == '0)); // R1
  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rst_n) |-> !m_ack && (io_stb == '0)); // R9
endmodule

// File: tb/tb_soc_bus_fabric.sv
`timescale 1ns/1ps
module tb_soc_bus_fabric;
  localparam int NIO = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        m_cyc = 0, m_stb = 0, m_we = 0;
  logic [29:0] m_adr = '0;
  logic [7:0]  m_sel = '0;
  logic [63:0] m_dat_w = '0;
  logic [63:0] m_dat_r;
  logic        m_ack, m_err;
  logic        bram_cyc, bram_stb, bram_we, dram_cyc, dram_stb, dram_we;
  logic [29:0] bram_adr, dram_adr;
  logic [7:0]  bram_sel, dram_sel;
  logic [63:0] bram_dat_w, dram_dat_w, bram_dat_r, dram_dat_r;
  logic        bram_ack = 0, dram_ack = 0;
  logic [NIO-1:0]    io_cyc, io_stb, io_ack;
  logic              io_we;
  logic [29:0]       io_adr;
  logic [3:0]        io_sel;
  logic [31:0]       io_dat_w;
  logic [NIO*32-1:0] io_dat_r;

  soc_bus_fabric dut (
    .clk(clk), .rst_n(rst_n), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
    .m_adr(m_adr), .m_sel(m_sel), .m_dat_w(m_dat_w), .m_dat_r(m_dat_r),
    .m_ack(m_ack), .m_err(m_err),
    .bram_cyc(bram_cyc), .bram_stb(bram_stb), .bram_we(bram_we), .bram_adr(bram_adr),
    .bram_sel(bram_sel), .bram_dat_w(bram_dat_w), .bram_dat_r(bram_dat_r), .bram_ack(bram_ack),
    .dram_cyc(dram_cyc), .dram_stb(dram_stb), .dram_we(dram_we), .dram_adr(dram_adr),
    .dram_sel(dram_sel), .dram_dat_w(dram_dat_w), .dram_dat_r(dram_dat_r), .dram_ack(dram_ack),
    .io_cyc(io_cyc), .io_stb(io_stb), .io_we(io_we), .io_adr(io_adr), .io_sel(io_sel),
    .io_dat_w(io_dat_w), .io_dat_r(io_dat_r), .io_ack(io_ack)
  );

  // Slave models: each acknowledges one clock after its strobe.
  logic [63:0] bram_m [16];
  logic [63:0] dram_m [16];
  int beat_log[$];

  assign bram_dat_r = bram_m[bram_adr[6:3]];
  assign dram_dat_r = dram_m[dram_adr[6:3]];

  initial for (int i = 0; i < 16; i++) begin bram_m[i] = '0; dram_m[i] = '0; end

  always @(posedge clk) begin
    bram_ack <= bram_cyc && bram_stb && !bram_ack;
    if (bram_cyc && bram_stb && !bram_ack && bram_we)
      for (int b = 0; b < 8; b++)
        if (bram_sel[b]) bram_m[bram_adr[6:3]][8*b +: 8] <= bram_dat_w[8*b +: 8];
    dram_ack <= dram_cyc && dram_stb && !dram_ack;
    if (dram_cyc && dram_stb && !dram_ack && dram_we)
      for (int b = 0; b < 8; b++)
        if (dram_sel[b]) dram_m[dram_adr[6:3]][8*b +: 8] <= dram_dat_w[8*b +: 8];
  end

  for (genvar p = 0; p < NIO; p++) begin : g_io
    logic [31:0] mem [16];
    logic        ack = 1'b0;
    initial for (int i = 0; i < 16; i++) mem[i] = '0;
    assign io_ack[p] = ack;
    assign io_dat_r[32*p +: 32] = mem[io_adr[5:2]];
    always @(posedge clk) begin
      ack <= io_cyc[p] && io_stb[p] && !ack;
      if (io_cyc[p] && io_stb[p] && !ack && io_we)
        for (int b = 0; b < 4; b++)
          if (io_sel[b]) mem[io_adr[5:2]][8*b +: 8] <= io_dat_w[8*b +: 8];
      if (io_cyc[p] && io_stb[p] && ack) beat_log.push_back(2*p + int'(io_adr[2]));
    end
  end

  // Scoreboard
  int n_cmp = 0, n_bad = 0, stray = 0, cyc_cnt = 0;
  bit resp_seen = 0;
  logic [63:0] exp_q[$];
  bit          err_q[$];
  bit          we_q[$];
  int          lat_q[$];
  string       tag_q[$];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  initial forever begin @(posedge clk); cyc_cnt++; end

  initial forever begin
    @(negedge clk);
    if ($countones({bram_stb, dram_stb, io_stb, m_err}) > 1) stray++;
    if (m_cyc && m_stb && (m_ack || m_err) && !resp_seen && exp_q.size() > 0) begin
      logic [63:0] e; bit ee, w; int l; string t;
      e = exp_q.pop_front(); ee = err_q.pop_front(); w = we_q.pop_front();
      l = lat_q.pop_front(); t = tag_q.pop_front();
      chk(t, "error flag", 64'(m_err), 64'(ee));
      chk(t, "ack flag", 64'(m_ack), 64'(!ee));
      chk(t, "latency", 64'(cyc_cnt), 64'(l));
      if (!w && !ee) chk(t, "read data", m_dat_r, e);
      resp_seen = 1;
    end
  end

  task automatic access(input logic [29:0] a, input bit we, input logic [7:0] sel,
                        input logic [63:0] wd, input logic [63:0] exp_rd, input bit exp_err,
                        input int exp_lat, input string tag, input int b0, input int b1);
    int nb;
    @(posedge clk); #1;
    exp_q.push_back(exp_rd); err_q.push_back(exp_err); we_q.push_back(we);
    lat_q.push_back(exp_lat); tag_q.push_back(tag);
    beat_log.delete();
    cyc_cnt = 0;
    m_cyc = 1; m_stb = 1; m_we = we; m_adr = a; m_sel = sel; m_dat_w = wd;
    wait (resp_seen);
    resp_seen = 0;
    nb = (b0 >= 0) + (b1 >= 0);
    chk(tag, "beat count", 64'(beat_log.size()), 64'(nb));
    if (nb >= 1 && beat_log.size() >= 1) chk(tag, "first beat", 64'(beat_log[0]), 64'(b0));
    if (nb == 2 && beat_log.size() >= 2) chk(tag, "second beat", 64'(beat_log[1]), 64'(b1));
    @(posedge clk); #1;
    m_cyc = 0; m_stb = 0; m_we = 0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9: idle after reset
    chk("R9", "m_ack", 64'(m_ack), 64'd0);
    chk("R9", "m_err", 64'(m_err), 64'd0);
    chk("R9", "strobes", 64'({bram_stb, dram_stb, io_stb}), 64'd0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    // R1: block RAM and DRAM legs, same offset, kept apart
    access(30'h0000_0040, 1, 8'hFF, 64'hDEAD_BEEF_0000_1111, 0, 0, 1, "R1 bram write", -1, -1);
    access(30'h1000_0040, 1, 8'hFF, 64'hCAFE_F00D_2222_3333, 0, 0, 1, "R1 dram write", -1, -1);
    access(30'h0000_0040, 0, 8'hFF, 0, 64'hDEAD_BEEF_0000_1111, 0, 1, "R1 bram read", -1, -1);
    access(30'h1000_0040, 0, 8'hFF, 0, 64'hCAFE_F00D_2222_3333, 0, 1, "R1 dram read", -1, -1);

    // R2: unmapped region answers with error at once
    access(30'h2000_0040, 0, 8'hFF, 0, 0, 1, 0, "R2 hole read", -1, -1);
    access(30'h2000_0000, 1, 8'hFF, 64'h1, 0, 1, 0, "R2 hole write", -1, -1);

    // R4 R8: two-beat write then read, peripheral 1, words 2 and 3
    access(30'h3000_1008, 1, 8'hFF, 64'h0123_4567_89AB_CDEF, 0, 0, 5, "R4 R8 io full write", 2, 3);
    access(30'h3000_1008, 0, 8'hFF, 0, 64'h0123_4567_89AB_CDEF, 0, 5, "R4 R5 io full read", 2, 3);

    // R3 R5: single-half reads
    access(30'h3000_1008, 0, 8'hF0, 0, 64'h0123_4567_0000_0000, 0, 3, "R3 R5 io high only", 3, -1);
    access(30'h3000_1008, 0, 8'h0F, 0, 64'h0000_0000_89AB_CDEF, 0, 3, "R3 R5 io low only", 2, -1);

    // R6: other peripherals at the same offset stay separate
    access(30'h3000_0008, 1, 8'hFF, 64'h5555_6666_7777_8888, 0, 0, 5, "R6 periph0 write", 0, 1);
    access(30'h3000_1008, 0, 8'hFF, 0, 64'h0123_4567_89AB_CDEF, 0, 5, "R6 periph1 reread", 2, 3);
    access(30'h3000_3000, 0, 8'hFF, 0, 64'h0, 0, 5, "R6 periph3 read", 6, 7);

    // R8: high-half partial write lands in the high word only
    access(30'h3000_2010, 1, 8'hC0, 64'hAABB_CCDD_1122_3344, 0, 0, 3, "R8 io high lanes write", 5, -1);
    access(30'h3000_2010, 0, 8'hFF, 0, 64'hAABB_0000_0000_0000, 0, 5, "R8 io readback", 4, 5);

    // R7: unmatched peripheral index
    access(30'h3000_5000, 0, 8'hFF, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 3, "R7 unmatched full", -1, -1);
    access(30'h3000_5000, 0, 8'h0F, 0, 64'h0000_0000_FFFF_FFFF, 0, 2, "R7 unmatched low", -1, -1);
    access(30'h3000_F000, 0, 8'hF0, 0, 64'hFFFF_FFFF_0000_0000, 0, 2, "R7 unmatched high", -1, -1);

    // R1: BRAM content untouched by all of the above
    access(30'h0000_0040, 0, 8'hFF, 0, 64'hDEAD_BEEF_0000_1111, 0, 1, "R1 bram final", -1, -1);
    chk("R1", "overlapping strobes", 64'(stray), 64'd0);

    repeat (3) @(posedge clk);
    summary();
    $finish;
  end
endmodule